// File: doc/BRIEF.md
# Memory-Mapped Times-Eight Scaler

This block is an AXI4-Lite slave that puts a small compute function behind two memory-mapped registers. Software writes a 32-bit operand into a writable register, then reads back that operand multiplied by eight from a second, read-only register. The product is formed combinationally from the stored operand, so the result is ready on the next read with no extra wait states.

Writes and reads run through separate state machines. The write side accepts the address and data channels in either order or together, holds each one until the other arrives, and then commits the operand. It returns an OKAY response. The read side captures the address, selects the word, and holds the data until the master takes it. Registers are spaced eight bytes apart inside a 0x80-byte window. Only the address bits that select a location inside that window are decoded.

Top module: `mmio_scale8_slave`

## Requirements
- R1: While reset (active-low, synchronous) is asserted and after it ends, BVALID and RVALID are low, AWREADY, WREADY and ARREADY are high, and the operand register reads as zero.
- R2: A write to offset 0x0 with all four strobe bits set stores WDATA. A later read of offset 0x0 returns it.
- R3: A read of offset 0x8 returns the stored operand shifted left by 3 bits, truncated to 32 bits.
- R4: A write to offset 0x0 updates only the byte lanes whose WSTRB bit is 1 (bit k covers WDATA[8k+7:8k]). The other bytes of the operand keep their old value.
- R5: Address and data may arrive in the same cycle or in either order. Once one channel has been accepted, its READY stays low until the write response completes, while the other channel stays ready.
- R6: After a write, BVALID is raised with BRESP = 2'b00 and stays high until a cycle with BREADY high.
- R7: After a read address is accepted, RVALID is raised with RRESP = 2'b00. RDATA does not change while RVALID is high and RREADY is low.
- R8: A read of any offset other than 0x0 and 0x8 returns zero.
- R9: A write to any offset other than 0x0 is acknowledged with OKAY but leaves the operand unchanged.
- R10: Only address bits [6:0] are decoded. Addresses that differ only in higher bits reach the same location (0x880 aliases 0x0, 0xF08 aliases 0x8, 0x8C0 aliases unmapped 0x40).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | 12 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 12 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
Several rules are checked on every cycle by the properties. Response valids hold and read data stays stable under backpressure, both response codes are OKAY, and the operand can only change as a write response opens. A channel that has been accepted alone closes its ready, a result-offset read returns eight times the operand, and an unmapped read returns zero. Only the bench's scenarios can show the values that land in storage: byte merging across all sixteen strobe patterns, the sweep of every word offset in the window, writes to non-zero offsets leaving the operand intact, and address aliasing above bit 6.

// File: rtl/mmio_scale_pkg.sv
package mmio_scale_pkg;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_RESP = 1'b1
    } wr_state_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_DATA = 1'b1
    } rd_state_e;

    localparam logic [1:0] RESP_OKAY = 2'b00;
    localparam int         LANE_W    = 8;

endpackage

// File: rtl/mmio_scale_unit.sv
module mmio_scale_unit #(
    parameter int DATA_W = 32,
    parameter int SHIFT  = 3
) (
    input  logic [DATA_W-1:0] opd_i,
    output logic [DATA_W-1:0] prod_o
);
    // Multiply by a power of two: a pure wire shift, upper bits drop off.
    generate
        if (SHIFT == 0) begin : g_pass
            assign prod_o = opd_i;
        end else begin : g_shift
            assign prod_o = {opd_i[DATA_W-SHIFT-1:0], {SHIFT{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/mmio_wr_path.sv
module mmio_wr_path
    import mmio_scale_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int WIN_W   = 7,
    parameter int OPD_OFF = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIN_W-1:0]     awaddr,
    input  logic                 awvalid,
    output logic                 awready,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [DATA_W/8-1:0]  wstrb,
    input  logic                 wvalid,
    output logic                 wready,
    output logic [1:0]           bresp,
    output logic                 bvalid,
    input  logic                 bready,
    output logic [DATA_W-1:0]    opd_o
);
    localparam int               STRB_W = DATA_W / LANE_W;
    localparam logic [WIN_W-1:0] OPD_A  = OPD_OFF[WIN_W-1:0];

    typedef struct packed {
        wr_state_e           st;
        logic                aw_hold;
        logic                w_hold;
        logic [WIN_W-1:0]    addr;
        logic [DATA_W-1:0]   data;
        logic [STRB_W-1:0]   strb;
        logic [DATA_W-1:0]   opd;
    } wr_regs_t;

    wr_regs_t q, d;

    logic                aw_fire, w_fire;
    logic                have_aw, have_w;
    logic [WIN_W-1:0]    eff_addr;
    logic [DATA_W-1:0]   eff_data;
    logic [STRB_W-1:0]   eff_strb;
    logic [DATA_W-1:0]   merged;

    assign awready = (q.st == WR_IDLE) && !q.aw_hold;
    assign wready  = (q.st == WR_IDLE) && !q.w_hold;
    assign aw_fire = awvalid && awready;
    assign w_fire  = wvalid && wready;
    assign bvalid  = (q.st == WR_RESP);
    assign bresp   = RESP_OKAY;
    assign opd_o   = q.opd;

    // Channel contents: a held copy wins over the live bus.
    always_comb begin
        have_aw  = q.aw_hold || aw_fire;
        have_w   = q.w_hold  || w_fire;
        eff_addr = q.aw_hold ? q.addr : awaddr;
        eff_data = q.w_hold  ? q.data : wdata;
        eff_strb = q.w_hold  ? q.strb : wstrb;
    end

    // Per-lane merge of new bytes into the stored operand.
    generate
        for (genvar b = 0; b < STRB_W; b++) begin : g_lane
            assign merged[b*LANE_W +: LANE_W] = eff_strb[b] ? eff_data[b*LANE_W +: LANE_W]
                                                            : q.opd[b*LANE_W +: LANE_W];
        end
    endgenerate

    always_comb begin
        d = q;
        if (aw_fire) begin
            d.aw_hold = 1'b1;
            d.addr    = awaddr;
        end
        if (w_fire) begin
            d.w_hold = 1'b1;
            d.data   = wdata;
            d.strb   = wstrb;
        end
        case (q.st)
            WR_IDLE: begin
                if (have_aw && have_w) begin
                    d.st      = WR_RESP;
                    d.aw_hold = 1'b0;
                    d.w_hold  = 1'b0;
                    if (eff_addr == OPD_A) begin
                        d.opd = merged;
                    end
                end
            end
            WR_RESP: begin
                if (bready) begin
                    d.st = WR_IDLE;
                end
            end
            default: d.st = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assert_bvalid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid);

    assert_bresp_okay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> bresp == RESP_OKAY);

    assert_opd_moves_with_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.opd) |-> bvalid && !$past(bvalid));

    assert_aw_closes_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        aw_fire && !w_fire && !q.w_hold |=> !awready && wready);

    assert_w_closes_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        w_fire && !aw_fire && !q.aw_hold |=> !wready && awready);
endmodule

// File: rtl/mmio_rd_path.sv
module mmio_rd_path
    import mmio_scale_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int WIN_W   = 7,
    parameter int OPD_OFF = 0,
    parameter int RES_OFF = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIN_W-1:0]     araddr,
    input  logic                 arvalid,
    output logic                 arready,
    output logic [DATA_W-1:0]    rdata,
    output logic [1:0]           rresp,
    output logic                 rvalid,
    input  logic                 rready,
    input  logic [DATA_W-1:0]    opd_i,
    input  logic [DATA_W-1:0]    prod_i
);
    localparam logic [WIN_W-1:0] OPD_A = OPD_OFF[WIN_W-1:0];
    localparam logic [WIN_W-1:0] RES_A = RES_OFF[WIN_W-1:0];

    typedef struct packed {
        rd_state_e         st;
        logic [DATA_W-1:0] data;
    } rd_regs_t;

    rd_regs_t          q, d;
    logic [DATA_W-1:0] sel_word;
    logic              ar_fire;

    assign arready = (q.st == RD_IDLE);
    assign ar_fire = arvalid && arready;
    assign rvalid  = (q.st == RD_DATA);
    assign rresp   = RESP_OKAY;
    assign rdata   = q.data;

    always_comb begin
        case (araddr)
            OPD_A:   sel_word = opd_i;
            RES_A:   sel_word = prod_i;
            default: sel_word = '0;
        endcase
    end

    always_comb begin
        d = q;
        case (q.st)
            RD_IDLE: begin
                if (ar_fire) begin
                    d.st   = RD_DATA;
                    d.data = sel_word;
                end
            end
            RD_DATA: begin
                if (rready) begin
                    d.st = RD_IDLE;
                end
            end
            default: d.st = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assert_rvalid_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata));

    assert_rresp_okay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> rresp == RESP_OKAY);

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ar_fire && araddr != OPD_A && araddr != RES_A |=> rdata == '0);

    assert_opd_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ar_fire && araddr == OPD_A |=> rdata == $past(opd_i));
endmodule

// File: rtl/mmio_scale8_slave.sv
module mmio_scale8_slave
    import mmio_scale_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 12,
    parameter int WIN_W       = 7,
    parameter int REG_STRIDE  = 8,
    parameter int SCALE_SHIFT = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    s_awaddr,
    input  logic                 s_awvalid,
    output logic                 s_awready,
    input  logic [DATA_W-1:0]    s_wdata,
    input  logic [DATA_W/8-1:0]  s_wstrb,
    input  logic                 s_wvalid,
    output logic                 s_wready,
    output logic [1:0]           s_bresp,
    output logic                 s_bvalid,
    input  logic                 s_bready,
    input  logic [ADDR_W-1:0]    s_araddr,
    input  logic                 s_arvalid,
    output logic                 s_arready,
    output logic [DATA_W-1:0]    s_rdata,
    output logic [1:0]           s_rresp,
    output logic                 s_rvalid,
    input  logic                 s_rready
);
    localparam int               OPD_OFF = 0;
    localparam int               RES_OFF = OPD_OFF + REG_STRIDE;
    localparam logic [WIN_W-1:0] RES_A   = RES_OFF[WIN_W-1:0];

    logic [DATA_W-1:0] opd;
    logic [DATA_W-1:0] prod;

    // Address bits above the window are not decoded.
    generate
        if (ADDR_W > WIN_W) begin : g_hi
            logic unused_addr_hi;
            assign unused_addr_hi = ^{s_awaddr[ADDR_W-1:WIN_W], s_araddr[ADDR_W-1:WIN_W]};
        end
    endgenerate

    mmio_wr_path #(
        .DATA_W  (DATA_W),
        .WIN_W   (WIN_W),
        .OPD_OFF (OPD_OFF)
    ) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .awaddr  (s_awaddr[WIN_W-1:0]),
        .awvalid (s_awvalid),
        .awready (s_awready),
        .wdata   (s_wdata),
        .wstrb   (s_wstrb),
        .wvalid  (s_wvalid),
        .wready  (s_wready),
        .bresp   (s_bresp),
        .bvalid  (s_bvalid),
        .bready  (s_bready),
        .opd_o   (opd)
    );

    mmio_scale_unit #(
        .DATA_W (DATA_W),
        .SHIFT  (SCALE_SHIFT)
    ) u_scale (
        .opd_i  (opd),
        .prod_o (prod)
    );

    mmio_rd_path #(
        .DATA_W  (DATA_W),
        .WIN_W   (WIN_W),
        .OPD_OFF (OPD_OFF),
        .RES_OFF (RES_OFF)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .araddr  (s_araddr[WIN_W-1:0]),
        .arvalid (s_arvalid),
        .arready (s_arready),
        .rdata   (s_rdata),
        .rresp   (s_rresp),
        .rvalid  (s_rvalid),
        .rready  (s_rready),
        .opd_i   (opd),
        .prod_i  (prod)
    );

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !s_bvalid && !s_rvalid && s_arready);

    assert_result_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_arvalid && s_arready && s_araddr[WIN_W-1:0] == RES_A
        |=> s_rdata == ($past(opd) << SCALE_SHIFT));
endmodule

// File: tb/mmio_scale8_slave_bench.sv
module mmio_scale8_slave_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] awaddr = '0;
    logic        awvalid = 1'b0;
    logic        awready;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        wvalid = 1'b0;
    logic        wready;
    logic [1:0]  bresp;
    logic        bvalid;
    logic        bready = 1'b0;
    logic [11:0] araddr = '0;
    logic        arvalid = 1'b0;
    logic        arready;
    logic [31:0] rdata;
    logic [1:0]  rresp;
    logic        rvalid;
    logic        rready = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    mmio_scale8_slave u_mmio_scale8_slave (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_aw(input logic [11:0] a);
        awaddr  = a;
        awvalid = 1'b1;
        while (!awready) @(negedge clk);
        @(negedge clk);
        awvalid = 1'b0;
    endtask

    task automatic send_w(input logic [31:0] v, input logic [3:0] s);
        wdata  = v;
        wstrb  = s;
        wvalid = 1'b1;
        while (!wready) @(negedge clk);
        @(negedge clk);
        wvalid = 1'b0;
    endtask

    // mode 0: same cycle, 1: address first, 2: data first
    task automatic do_write(input logic [11:0] a, input logic [31:0] v, input logic [3:0] s,
                            input int mode, input int bdelay);
        if (mode == 1) begin
            send_aw(a);
            chk(!awready && wready, "R5 aw-first ready", {awready, wready}, 32'h1);
            send_w(v, s);
        end else if (mode == 2) begin
            send_w(v, s);
            chk(!wready && awready, "R5 w-first ready", {wready, awready}, 32'h1);
            send_aw(a);
        end else begin
            fork
                send_aw(a);
                send_w(v, s);
            join
        end
        while (!bvalid) @(negedge clk);
        chk(bresp == 2'b00, "R6 bresp", bresp, 0);
        for (int k = 0; k < bdelay; k++) begin
            @(negedge clk);
            chk(bvalid, "R6 bvalid hold", bvalid, 1);
        end
        bready = 1'b1;
        @(negedge clk);
        bready = 1'b0;
        chk(!bvalid, "R6 bvalid drop", bvalid, 0);
    endtask

    task automatic do_read(input logic [11:0] a, input int rdelay, output logic [31:0] v);
        araddr  = a;
        arvalid = 1'b1;
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        chk(rvalid, "R7 rvalid", rvalid, 1);
        chk(rresp == 2'b00, "R7 rresp", rresp, 0);
        v = rdata;
        for (int k = 0; k < rdelay; k++) begin
            @(negedge clk);
            chk(rvalid && rdata == v, "R7 rdata stable", rdata, v);
        end
        rready = 1'b1;
        @(negedge clk);
        rready = 1'b0;
    endtask

    task automatic expect_read(input logic [11:0] a, input int rdelay, input logic [31:0] exp, input string req);
        logic [31:0] got;
        do_read(a, rdelay, got);
        chk(got == exp, req, got, exp);
    endtask

    initial begin
        logic [31:0] v, cur, exp;
        repeat (3) @(negedge clk);
        chk(!bvalid && !rvalid, "R1 valids in reset", {bvalid, rvalid}, 0);
        chk(awready && wready && arready, "R1 readies in reset", {awready, wready, arready}, 32'h7);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bvalid && !rvalid, "R1 valids after reset", {bvalid, rvalid}, 0);
        expect_read(12'h000, 0, 32'h0, "R1 operand zero");
        expect_read(12'h008, 0, 32'h0, "R1 result zero");

        // R2/R3: walking ones and edge patterns, all channel orders
        for (int i = 0; i < 35; i++) begin
            if (i < 32) v = 32'h1 << i;
            else if (i == 32) v = 32'hFFFF_FFFF;
            else if (i == 33) v = 32'h1FFF_FFFF;
            else v = 32'hE000_0001;
            do_write(12'h000, v, 4'hF, i % 3, i % 3);
            expect_read(12'h000, i % 2, v, "R2 operand readback");
            expect_read(12'h008, i % 4, v << 3, "R3 result");
        end

        // R4: every strobe pattern
        for (int s = 0; s < 16; s++) begin
            do_write(12'h000, 32'h1122_3344, 4'hF, 0, 0);
            do_write(12'h000, 32'hAABB_CCDD, s[3:0], s % 3, 0);
            exp = 32'h1122_3344;
            for (int b = 0; b < 4; b++)
                if (s[b]) exp[b*8 +: 8] = 8'hAA + 8'h11 * b[7:0] == 8'hAA ? 8'hDD : exp[b*8 +: 8];
            exp = {s[3] ? 8'hAA : 8'h11, s[2] ? 8'hBB : 8'h22, s[1] ? 8'hCC : 8'h33, s[0] ? 8'hDD : 8'h44};
            expect_read(12'h000, 0, exp, "R4 strobe merge");
        end

        // R8: sweep word offsets
        cur = 32'h0000_0ABC;
        do_write(12'h000, cur, 4'hF, 0, 0);
        for (int off = 0; off < 128; off += 4) begin
            if (off == 0) exp = cur;
            else if (off == 8) exp = cur << 3;
            else exp = 32'h0;
            expect_read(off[11:0], off % 3, exp, "R8 offset sweep");
        end

        // R9: writes to non-zero offsets change nothing
        for (int off = 4; off < 128; off += 4) begin
            do_write(off[11:0], ~cur, 4'hF, off % 3, 1);
            expect_read(12'h000, 0, cur, "R9 operand unchanged");
        end
        expect_read(12'h008, 0, cur << 3, "R9 result unchanged");

        // R10: upper address bits ignored
        do_write(12'h880, 32'h1357_9BDF, 4'hF, 1, 0);
        expect_read(12'h000, 0, 32'h1357_9BDF, "R10 write alias");
        expect_read(12'hF08, 0, 32'h1357_9BDF << 3, "R10 read alias result");
        do_write(12'h8C0, 32'h0, 4'hF, 2, 0);
        expect_read(12'h480, 0, 32'h1357_9BDF, "R10 unmapped alias");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %h expected %h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule